// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers twenty condition flags into an indicator register, qualifies each flag with its own bit of a 64-bit enable mask, and picks the lowest-numbered enabled flag as the one to service. For the chosen flag it raises a request and presents a branch target equal to an 18-bit base address plus the flag number. Only one condition is in service at a time: the request and its target stay fixed until the processor acknowledges, and the acknowledge clears exactly the flag that was serviced.

Software reads and writes the indicator flags, the mask and the base address through a small register port. The mask has fixed fields: its first twenty bits always read as one, the next band (bits 20 to 47) holds whatever software last wrote, and the upper bits always read as zero. On every data word, field bit k travels on wire k of the bus.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request is low, the target is 0, the indicator and base read as 0, and the mask reads with bits 0 to 19 set and every other bit clear.
- R2: Mask readback (select 1) shows bits 0 to 19 as one and bits 48 to 63 as zero whatever is written, and bits 20 to 47 as the last written value.
- R3: Indicator i is enabled by mask bit i; since mask bits 0 to 19 are fixed at one, every indicator raises a request even after software writes an all-zero mask.
- R4: When no request is outstanding and enabled flags are pending, the request rises on the next clock edge and the target is the base plus the lowest pending flag number.
- R5: The target is truncated to 18 bits, so base 0x3FFFF plus flag 5 gives 0x00004.
- R6: While a request waits for acknowledge, the request stays high and the target stays unchanged even if a lower-numbered flag is set or the base is rewritten.
- R7: Acknowledge with a request outstanding clears only the serviced flag; other pending flags remain.
- R8: A flag set input arriving in the same cycle as the acknowledge that clears that flag wins: the flag stays set and is serviced again.
- R9: Acknowledge with no request outstanding has no effect on the flags or on the request.
- R10: A software write to the indicator (select 0) or base (select 2) replaces the register at the next clock edge; a written indicator flag is serviced like a set input. Select 3 reads as zero.
- R11: After an acknowledged request the request is low for at least one cycle before the next condition is taken.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ind_set | input | 20 | One-cycle set strobes, bit i sets flag i |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Register select: 0 flags, 1 mask, 2 base, 3 none |
| sw_wdata | input | 64 | Software write data |
| sw_rdata | output | 64 | Read data of the selected register, combinational |
| irq_ack | input | 1 | Acknowledge of the outstanding request |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 18 | Branch target for the request |

## Verification
Priority is tried with single flags at both ends of the range, with several flags raised together, and with a lower-numbered flag arriving while a higher-numbered one waits, which separates a frozen selection from a live one. Acknowledge is exercised alone, together with a re-set of the same flag, and with nothing outstanding, telling apart clearing one flag, clearing all, and clearing nothing. Base values near the top of the 18-bit range show whether the target wraps, and all-zero and all-one mask writes show which mask fields are stored.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    SEL_FLAGS = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_BASE  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/prio_flag_reg.sv
module prio_flag_reg #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] flags_q
);
  logic [N-1:0] after_wr;

  assign after_wr = wr_en ? wr_data : flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (after_wr & ~clr_vec) | set_vec;
  end

  // R8: a set strobe always leaves its flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  // R7: a cleared flag not set again is gone
  a_r7_clear_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((flags_q & $past(clr_vec) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/prio_cfg_regs.sv
module prio_cfg_regs #(
  parameter int DATA_W    = 64,
  parameter int ONES_LAST = 19,
  parameter int RW_LAST   = 47,
  parameter int ADDR_W    = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              base_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_full,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (base_wr) base_q <= wdata[ADDR_W-1:0];
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_mask_bit
    if (k <= ONES_LAST) begin : g_one
      assign mask_full[k] = 1'b1;
    end else if (k <= RW_LAST) begin : g_rw
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       bit_q <= 1'b0;
        else if (mask_wr) bit_q <= wdata[k];
      end
      assign mask_full[k] = bit_q;
    end else begin : g_zero
      assign mask_full[k] = 1'b0;
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N     = 20,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx
);
  logic [N:0] none_before;

  assign none_before[0] = 1'b1;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]         = req[i] & none_before[i];
    assign none_before[i+1] = none_before[i] & ~req[i];
  end
  assign any = ~none_before[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_IND     = 20,
  parameter int DATA_W    = 64,
  parameter int ONES_LAST = 19,
  parameter int RW_LAST   = 47,
  parameter int ADDR_W    = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IND-1:0]  ind_set,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [ADDR_W-1:0] irq_vec
);
  import prio_irq_pkg::*;

  localparam int IDX_W = (N_IND > 1) ? $clog2(N_IND) : 1;

  function automatic logic [ADDR_W-1:0] form_vector(
    input logic [ADDR_W-1:0] base, input logic [IDX_W-1:0] idx);
    return base + ADDR_W'(idx);
  endfunction

  reg_sel_e              sel;
  logic                  flags_wr, mask_wr, base_wr;
  logic [N_IND-1:0]      flags_q, pend, pick_oh, clr_vec;
  logic [DATA_W-1:0]     mask_full;
  logic [ADDR_W-1:0]     base_q;
  logic                  pick_any, take_ev, serve_done;
  logic [IDX_W-1:0]      pick_idx;
  logic                  busy_q;
  logic [IDX_W-1:0]      srv_idx_q;
  logic [ADDR_W-1:0]     vec_q;

  assign sel      = reg_sel_e'(sw_sel);
  assign flags_wr = sw_we && (sel == SEL_FLAGS);
  assign mask_wr  = sw_we && (sel == SEL_MASK);
  assign base_wr  = sw_we && (sel == SEL_BASE);

  prio_flag_reg #(.N(N_IND)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(flags_wr),
    .wr_data(sw_wdata[N_IND-1:0]), .clr_vec(clr_vec),
    .set_vec(ind_set), .flags_q(flags_q)
  );

  prio_cfg_regs #(.DATA_W(DATA_W), .ONES_LAST(ONES_LAST),
                  .RW_LAST(RW_LAST), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .base_wr(base_wr),
    .wdata(sw_wdata), .mask_full(mask_full), .base_q(base_q)
  );

  assign pend = flags_q & mask_full[N_IND-1:0];

  prio_pick #(.N(N_IND), .IDX_W(IDX_W)) u_pick (
    .req(pend), .any(pick_any), .grant(pick_oh), .idx(pick_idx)
  );

  assign take_ev    = !busy_q && pick_any;
  assign serve_done = busy_q && irq_ack;
  assign clr_vec    = serve_done ? (N_IND'(1) << srv_idx_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      srv_idx_q <= '0;
      vec_q     <= '0;
    end else if (serve_done) begin
      busy_q    <= 1'b0;
    end else if (take_ev) begin
      busy_q    <= 1'b1;
      srv_idx_q <= pick_idx;
      vec_q     <= form_vector(base_q, pick_idx);
    end
  end

  assign irq_req = busy_q;
  assign irq_vec = vec_q;

  always_comb begin
    case (sel)
      SEL_FLAGS: sw_rdata = DATA_W'(flags_q);
      SEL_MASK:  sw_rdata = mask_full;
      SEL_BASE:  sw_rdata = DATA_W'(base_q);
      default:   sw_rdata = '0;
    endcase
  end

  // R4: at most one condition picked
  a_r4_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));
  // R4: an idle controller with pending flags raises the request
  a_r4_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && pick_any) |=> irq_req);
  // R6: request and target hold until acknowledge
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));
  // R11: one cycle low after an acknowledged request
  a_r11_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);
  // R9: stray acknowledge with nothing pending changes nothing
  a_r9_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && irq_ack && !pick_any) |=> !irq_req);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int N = 20;
  localparam int DW = 64;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ind_set = '0;
  logic          sw_we = 1'b0;
  logic [1:0]    sw_sel = 2'd0;
  logic [DW-1:0] sw_wdata = '0;
  logic [DW-1:0] sw_rdata;
  logic          irq_ack = 1'b0;
  logic          irq_req;
  logic [AW-1:0] irq_vec;

  int errors = 0;
  int checks = 0;
  logic [AW-1:0] base_m = '0;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ind_set(ind_set), .sw_we(sw_we),
    .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mask_model(input logic [DW-1:0] w);
    logic [DW-1:0] m;
    for (int k = 0; k < DW; k++)
      m[k] = (k < 20) ? 1'b1 : ((k < 48) ? w[k] : 1'b0);
    return m;
  endfunction

  function automatic logic [AW-1:0] vec_model(input logic [AW-1:0] b,
                                              input int idx);
    logic [31:0] s;
    s = 32'(b) + 32'(idx);
    return s[AW-1:0];
  endfunction

  task automatic rd(input logic [1:0] sel, output logic [DW-1:0] v);
    sw_sel = sel;
    #1;
    v = sw_rdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
    tick();
    sw_we = 1'b0;
    if (sel == 2'd2) base_m = d[AW-1:0];
  endtask

  task automatic pulse_set(input logic [N-1:0] s);
    ind_set = s;
    tick();
    ind_set = '0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 req", DW'(irq_req), '0);
    check("R1 vec", DW'(irq_vec), '0);
    rd(2'd0, v); check("R1 flags", v, '0);
    rd(2'd1, v); check("R1 mask", v, mask_model('0));
    rd(2'd2, v); check("R1 base", v, '0);
  endtask

  task automatic t_mask_fields();
    logic [DW-1:0] v;
    wr(2'd1, '1);
    rd(2'd1, v); check("R2 mask all ones", v, mask_model('1));
    wr(2'd1, 64'h5A3C_96F0_0FF0_1234);
    rd(2'd1, v); check("R2 mask pattern", v, mask_model(64'h5A3C_96F0_0FF0_1234));
    rd(2'd3, v); check("R10 select 3 reads zero", v, '0);
  endtask

  task automatic t_mask_no_gate();
    logic [DW-1:0] v;
    wr(2'd1, '0);
    rd(2'd1, v); check("R3 mask after zero write", v, mask_model('0));
    wr(2'd2, 64'd1000);
    pulse_set(N'(1) << 19);
    tick();
    check("R3 req with zero mask", DW'(irq_req), 1);
    check("R3 vec flag 19", DW'(irq_vec), DW'(vec_model(base_m, 19)));
    pulse_ack();
  endtask

  task automatic t_priority();
    logic [DW-1:0] v;
    wr(2'd2, 64'd64);
    pulse_set((N'(1) << 3) | (N'(1) << 9) | (N'(1) << 17));
    check("R4 no req one edge after set", DW'(irq_req), 0);
    tick();
    check("R4 req", DW'(irq_req), 1);
    check("R4 lowest flag 3", DW'(irq_vec), DW'(vec_model(base_m, 3)));
    pulse_ack();
    check("R11 gap after ack", DW'(irq_req), 0);
    rd(2'd0, v);
    check("R7 only flag 3 cleared", v, DW'((N'(1) << 9) | (N'(1) << 17)));
    tick();
    check("R4 next flag 9", DW'(irq_vec), DW'(vec_model(base_m, 9)));
    pulse_ack(); tick();
    check("R4 next flag 17", DW'(irq_vec), DW'(vec_model(base_m, 17)));
    pulse_ack();
    rd(2'd0, v); check("R7 all serviced", v, '0);
  endtask

  task automatic t_flag0();
    wr(2'd2, 64'd77);
    pulse_set(N'(1)); tick();
    check("R4 flag 0 vec", DW'(irq_vec), DW'(vec_model(base_m, 0)));
    pulse_ack();
  endtask

  task automatic t_wrap();
    wr(2'd2, 64'h3FFFF);
    pulse_set(N'(1) << 5); tick();
    check("R5 wrap", DW'(irq_vec), 64'h4);
    pulse_ack();
  endtask

  task automatic t_freeze();
    wr(2'd2, 64'd100);
    pulse_set(N'(1) << 10); tick();
    check("R6 first vec", DW'(irq_vec), DW'(vec_model(base_m, 10)));
    pulse_set(N'(1) << 2);
    wr(2'd2, 64'd500);
    tick();
    check("R6 req held", DW'(irq_req), 1);
    check("R6 vec frozen", DW'(irq_vec), DW'(vec_model(100, 10)));
    pulse_ack();
    check("R11 low after ack", DW'(irq_req), 0);
    tick();
    check("R6 later flag 2 new base", DW'(irq_vec), DW'(vec_model(base_m, 2)));
    pulse_ack();
  endtask

  task automatic t_set_wins();
    logic [DW-1:0] v;
    wr(2'd2, 64'd40);
    pulse_set(N'(1) << 7); tick();
    ind_set = N'(1) << 7;
    pulse_ack();
    ind_set = '0;
    rd(2'd0, v); check("R8 flag 7 kept", v, DW'(N'(1) << 7));
    tick();
    check("R8 serviced again", DW'(irq_req), 1);
    check("R8 vec", DW'(irq_vec), DW'(vec_model(base_m, 7)));
    pulse_ack();
  endtask

  task automatic t_idle_ack();
    logic [DW-1:0] v;
    pulse_ack();
    check("R9 idle ack no req", DW'(irq_req), 0);
    rd(2'd0, v); check("R9 idle ack flags", v, '0);
    pulse_set(N'(1) << 4);
    pulse_ack();
    check("R9 req after early ack", DW'(irq_req), 1);
    rd(2'd0, v); check("R9 flag 4 intact", v, DW'(N'(1) << 4));
    pulse_ack();
  endtask

  task automatic t_sw_write();
    logic [DW-1:0] v;
    wr(2'd2, 64'd300);
    rd(2'd2, v); check("R10 base readback", v, 64'd300);
    wr(2'd0, DW'(N'(1) << 15));
    rd(2'd0, v); check("R10 flags written", v, DW'(N'(1) << 15));
    tick();
    check("R10 written flag serviced", DW'(irq_vec), DW'(vec_model(base_m, 15)));
    pulse_ack();
    rd(2'd0, v); check("R10 flags cleared", v, '0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mask_fields();
    t_mask_no_gate();
    t_priority();
    t_flag0();
    t_wrap();
    t_freeze();
    t_set_wins();
    t_idle_ack();
    t_sw_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule